// File: doc/BRIEF.md
# Per-Thread Next-PC Unit with Condition-Flag Branching

This block runs beside each thread slot of a small SIMT compute core. It holds a 3-bit condition register recording whether the last compare came out positive, zero or negative. From the current PC it works out the PC the scheduler should load next.

A compare instruction leaves its outcome in the low three bits of the ALU result. When the decoder raises the flag-write strobe, the unit copies those bits into the condition register during the core's update phase. In the execute phase the unit chooses the next PC. A branch instruction selects the 8-bit immediate target if any bit of its 3-bit condition mask coincides with a set flag. In every other case the unit falls through to the current PC plus one. A disabled thread slot freezes both registers.

Top module: `pcu_top`

## Requirements
- R1: While `rst` is high, `nextPc` and `flagReg` both become zero on the next clock edge.
- R2: With `threadEn` high, `coreState` equal to 3'b110 (update) and `flagWe` high, `flagReg` takes `aluResult[2:0]` on the clock edge. Bit 2 means positive, bit 1 zero and bit 0 negative.
- R3: `flagWe` has no effect in any `coreState` other than 3'b110, and `flagReg` holds its value there.
- R4: With `threadEn` high, `coreState` equal to 3'b101 (execute) and `pcSel` low, `nextPc` becomes `curPc + 1` on the clock edge.
- R5: With `threadEn` high, `coreState` equal to 3'b101 and `pcSel` high, `nextPc` becomes `branchImm` when `condMask & flagReg` is nonzero. Mask bit i tests flag bit i.
- R6: With `threadEn` high, `coreState` equal to 3'b101 and `pcSel` high, `nextPc` becomes `curPc + 1` when `condMask & flagReg` is zero.
- R7: In any `coreState` other than 3'b101, `nextPc` holds its value.
- R8: With `threadEn` low, neither `nextPc` nor `flagReg` changes in any phase.
- R9: The fall-through address wraps modulo 256, so a `curPc` of 255 yields a `nextPc` of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| threadEn | input | 1 | Thread slot active |
| coreState | input | 3 | Scheduler phase (3'b101 execute, 3'b110 update) |
| curPc | input | 8 | PC of the instruction in flight |
| condMask | input | 3 | Decoded branch condition mask |
| branchImm | input | 8 | Decoded branch target |
| pcSel | input | 1 | High for a branch instruction |
| flagWe | input | 1 | Decoded condition-register write strobe |
| aluResult | input | 8 | ALU output; bits [2:0] carry the compare outcome |
| nextPc | output | 8 | PC for the scheduler to load |
| flagReg | output | 3 | Condition register contents |

## Verification
Two functions of the block can meet in one cycle. The first is the flag-write strobe. The second is a branch evaluation, which reads the flags.

The bench provokes this in two ways. It raises `flagWe` with a fresh ALU result during the execute phase of a branch. It also drives an update-phase flag write directly before an execute phase.

In the first case the branch must use the old flags, and the flags must not change. In the second case the branch must use the newly written flags. A behavioural reference model is compared with both outputs after every clock, so any mixing of these two paths shows up as a mismatch.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam int PHASE_W = 3;
  localparam logic [PHASE_W-1:0] PH_EXECUTE = 3'b101;
  localparam logic [PHASE_W-1:0] PH_UPDATE  = 3'b110;

  typedef struct packed {
    logic computePc;
    logic latchFlags;
  } pcuStrobes_t;
endpackage

// File: rtl/pcu_ctrl.sv
module pcu_ctrl
  import pcu_pkg::*;
(
  input  logic               threadEn,
  input  logic [PHASE_W-1:0] coreState,
  input  logic               flagWe,
  output pcuStrobes_t        strb
);
  always_comb begin
    strb.computePc  = threadEn && (coreState == PH_EXECUTE);
    strb.latchFlags = threadEn && (coreState == PH_UPDATE) && flagWe;
  end
endmodule

// File: rtl/pcu_dpath.sv
module pcu_dpath
  import pcu_pkg::*;
#(
  parameter int PC_W   = 8,
  parameter int FLAG_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  pcuStrobes_t       strb,
  input  logic [PC_W-1:0]   curPc,
  input  logic [FLAG_W-1:0] condMask,
  input  logic [PC_W-1:0]   branchImm,
  input  logic              pcSel,
  input  logic [DATA_W-1:0] aluResult,
  output logic [PC_W-1:0]   nextPc,
  output logic [FLAG_W-1:0] flagReg
);
  localparam logic [PC_W-1:0] PC_STEP = PC_W'(1);

  logic              condHit;
  logic [PC_W-1:0]   seqPc;
  logic [FLAG_W-1:0] cmpBits;

  assign condHit = |(condMask & flagReg);
  assign seqPc   = curPc + PC_STEP;
  assign cmpBits = aluResult[FLAG_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      nextPc <= '0;
    end else if (strb.computePc) begin
      nextPc <= (pcSel && condHit) ? branchImm : seqPc;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flagReg <= '0;
    end else if (strb.latchFlags) begin
      flagReg <= cmpBits;
    end
  end

  // R2
  flag_load_chk: assert property (@(posedge clk) disable iff (rst)
    strb.latchFlags |=> flagReg == $past(aluResult[FLAG_W-1:0]));
  // R3
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.latchFlags |=> $stable(flagReg));
  // R4
  seq_pc_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.computePc && !pcSel) |=> nextPc == PC_W'($past(curPc) + PC_STEP));
  // R5
  branch_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.computePc && pcSel && (|(condMask & flagReg))) |=> nextPc == $past(branchImm));
  // R7
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.computePc |=> $stable(nextPc));
endmodule

// File: rtl/pcu_top.sv
module pcu_top
  import pcu_pkg::*;
#(
  parameter int PC_W   = 8,
  parameter int FLAG_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              threadEn,
  input  logic [2:0]        coreState,
  input  logic [PC_W-1:0]   curPc,
  input  logic [FLAG_W-1:0] condMask,
  input  logic [PC_W-1:0]   branchImm,
  input  logic              pcSel,
  input  logic              flagWe,
  input  logic [DATA_W-1:0] aluResult,
  output logic [PC_W-1:0]   nextPc,
  output logic [FLAG_W-1:0] flagReg
);
  pcuStrobes_t strb;

  pcu_ctrl u_ctrl (
    .threadEn  (threadEn),
    .coreState (coreState),
    .flagWe    (flagWe),
    .strb      (strb)
  );

  pcu_dpath #(.PC_W(PC_W), .FLAG_W(FLAG_W), .DATA_W(DATA_W)) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .curPc     (curPc),
    .condMask  (condMask),
    .branchImm (branchImm),
    .pcSel     (pcSel),
    .aluResult (aluResult),
    .nextPc    (nextPc),
    .flagReg   (flagReg)
  );

  // R8
  idle_slot_chk: assert property (@(posedge clk) disable iff (rst)
    !threadEn |=> ($stable(nextPc) && $stable(flagReg)));
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (nextPc == '0 && flagReg == '0));
endmodule

// File: tb/tb_pcu_top.sv
`timescale 1ns/1ps
module tb_pcu_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       threadEn = 1'b0;
  logic [2:0] coreState = 3'd0;
  logic [7:0] curPc = 8'd0;
  logic [2:0] condMask = 3'd0;
  logic [7:0] branchImm = 8'd0;
  logic       pcSel = 1'b0;
  logic       flagWe = 1'b0;
  logic [7:0] aluResult = 8'd0;
  logic [7:0] nextPc;
  logic [2:0] flagReg;

  int tests = 0;
  int fails = 0;
  int refPc = 0;
  int refFlags = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pcu_top dut (
    .clk(clk), .rst(rst), .threadEn(threadEn), .coreState(coreState),
    .curPc(curPc), .condMask(condMask), .branchImm(branchImm), .pcSel(pcSel),
    .flagWe(flagWe), .aluResult(aluResult), .nextPc(nextPc), .flagReg(flagReg)
  );

  task automatic model();
    int oldFlags = refFlags;
    if (rst) begin
      refPc = 0; refFlags = 0;
    end else if (threadEn) begin
      if (coreState == 3'd5)
        refPc = (pcSel && ((int'(condMask) & oldFlags) != 0)) ? int'(branchImm) : (int'(curPc) + 1) % 256;
      if (coreState == 3'd6 && flagWe)
        refFlags = int'(aluResult) & 7;
    end
  endtask

  task automatic cyc(input string req);
    @(posedge clk);
    model();
    #1;
    tests++;
    if (int'(nextPc) != refPc || int'(flagReg) != refFlags) begin
      fails++;
      $display("FAIL %s: nextPc=%0d flagReg=%0d expected nextPc=%0d flagReg=%0d",
               req, nextPc, flagReg, refPc, refFlags);
    end
  endtask

  task automatic drive(input bit en, input logic [2:0] st, input logic [7:0] pc,
                       input logic [2:0] msk, input logic [7:0] imm, input bit sel,
                       input bit we, input logic [7:0] alu);
    threadEn = en; coreState = st; curPc = pc; condMask = msk;
    branchImm = imm; pcSel = sel; flagWe = we; aluResult = alu;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    drive(1, 3'd5, 8'd77, 3'd7, 8'd9, 1, 1, 8'h07);
    cyc("R1"); cyc("R1");
    rst = 1'b0;
    // R2: set positive flag
    drive(1, 3'd6, 8'd0, 3'd0, 8'd0, 0, 1, 8'b1111_1100);
    cyc("R2");
    // R5: mask positive matches -> branch
    drive(1, 3'd5, 8'd10, 3'b100, 8'd200, 1, 0, 8'd0);
    cyc("R5");
    // R6: mask negative only -> fall through
    drive(1, 3'd5, 8'd10, 3'b001, 8'd200, 1, 0, 8'd0);
    cyc("R6");
    // R4
    drive(1, 3'd5, 8'd41, 3'b111, 8'd3, 0, 0, 8'd0);
    cyc("R4");
    // R9
    drive(1, 3'd5, 8'd255, 3'b000, 8'd3, 0, 0, 8'd0);
    cyc("R9");
    // R3: write strobe during execute ignored, branch uses old flags
    drive(1, 3'd5, 8'd20, 3'b100, 8'd99, 1, 1, 8'h01);
    cyc("R3");
    drive(1, 3'd3, 8'd20, 3'b100, 8'd99, 1, 1, 8'h02);
    cyc("R3");
    // R7: non-execute phases hold nextPc
    drive(1, 3'd4, 8'd50, 3'b111, 8'd1, 1, 0, 8'd0);
    cyc("R7");
    // R2 then branch on fresh zero flag
    drive(1, 3'd6, 8'd0, 3'd0, 8'd0, 0, 1, 8'h02);
    cyc("R2");
    drive(1, 3'd5, 8'd60, 3'b010, 8'd133, 1, 0, 8'd0);
    cyc("R5");
    // R8: disabled slot freezes everything
    drive(0, 3'd6, 8'd0, 3'd0, 8'd0, 0, 1, 8'h01);
    cyc("R8");
    drive(0, 3'd5, 8'd5, 3'b111, 8'd11, 1, 0, 8'd0);
    cyc("R8");
    for (int i = 0; i < 400; i++) begin
      logic [2:0] st;
      st = ($urandom % 3 == 0) ? 3'($urandom) : (($urandom % 2) ? 3'd5 : 3'd6);
      drive(($urandom % 8) != 0, st, 8'($urandom), 3'($urandom), 8'($urandom),
            1'($urandom), 1'($urandom), 8'($urandom));
      cyc("R7");
    end
    rst = 1'b1;
    cyc("R1");
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule